// File: doc/BRIEF.md
# Indexed-Access Watchdog Timer

This block is a watchdog counter that sits behind a two-byte indirect host port inside an I/O bridge. The host first writes a register index to the port's first byte. It then reads or writes the selected register through the second byte. Behind the port are an enable control, an expiry-signal selector, a timeout value split into three bytes, and a kick/status register.

Once enabled, the counter starts from the programmed timeout and decrements on each pulse of a time-base strobe. In a real system that strobe runs at 32.768 kHz. When a decrement would go below zero, the block expires. On expiry it raises a one-cycle pulse on the reset output or on the NMI output, whichever the selector names, and sets a sticky fired flag. Software keeps the system alive by writing the kick bit before the count runs out.

The fired flag is cleared only by the power-on reset or by software. A system reset leaves it in place, so software can see after a restart that the watchdog caused it.

Top module: `wdt_indexed`

## Requirements
- R1: Port offset 0 (`host_addr`=0) writes the register index. Offset 1 reads or writes the indexed register. A read at offset 0 returns the current index.
- R2: Index 0x37 is control. Its bit 6 is the enable. A write that changes the enable from 0 to 1 loads the counter from the timeout. Writing 1 while already enabled does not restart the count.
- R3: Index 0x38 is the signal selector. Bits 7:4 are stored. Bits 3:0 always read back as 0.
- R4: Indices 0x39, 0x3A and 0x3B hold timeout bits 7:0, 15:8 and 23:16. With timeout T, expiry happens on the (T+1)-th tick after the counter is loaded.
- R5: Index 0x3C bit 6 is a kick. While enabled, writing 1 to it reloads the counter from the timeout. The bit always reads back as 0.
- R6: On expiry, a one-cycle high pulse appears on `wdt_rst_o` if the selector code is 0xD, or on `wdt_nmi_o` if it is 0xC. Any other code gives no pulse. After expiry the counter reloads and keeps running.
- R7: Index 0x3C bit 7 is the fired flag. It is set on expiry. Writing 0 to it clears it and writing 1 has no effect. It survives `rst_n` and is cleared by `por_n`.
- R8: While the enable is 0, the counter holds its value, `tick_en` is ignored, and no expiry can occur.
- R9: Indices other than 0x37 to 0x3C read back as 0x00, and writes to them change nothing.
- R10: After reset, control, selector and timeout all read 0x00 and both pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low. Clears everything, including the fired flag |
| rst_n | input | 1 | System reset, active low. Clears everything except the fired flag |
| tick_en | input | 1 | One-cycle time-base strobe that advances the counter |
| host_wr | input | 1 | Host write strobe for the addressed port byte |
| host_addr | input | 1 | Port byte select: 0 for index, 1 for data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the addressed port byte |
| wdt_rst_o | output | 1 | One-cycle expiry pulse when reset signalling is selected |
| wdt_nmi_o | output | 1 | One-cycle expiry pulse when NMI signalling is selected |

## Verification
The bench counts ticks exactly to the expiry edge.
- An off-by-one in the terminal value would pulse a tick early or a tick late.
- A counter that ignores the middle timeout byte would fire long before tick 257.

Kicks given mid-count and enable toggles given mid-count are checked for the same exact tick:
- A kick that fails to reload, or reloads while disabled, would fire too early.
- A disable that does not freeze the count would fire too early.
- A re-enable that fails to reload would also fire at the wrong tick.

Three further cases are covered:
- An unknown selector code must still set the fired flag but drive no pulse. Routing on only one bit of the selector would leak a pulse.
- After a system reset the fired flag must read back set. Clearing it on `rst_n` would destroy the only evidence of the watchdog restart.
- Writing 1 to the fired bit must leave it unchanged. Treating that write as a clear would lose the flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] IDX_CTRL = 8'h37;
  localparam logic [7:0] IDX_SSEL = 8'h38;
  localparam logic [7:0] IDX_TMO0 = 8'h39;
  localparam logic [7:0] IDX_KICK = 8'h3C;
  localparam int EN_BIT     = 6;
  localparam int KICK_BIT   = 6;
  localparam int FIRED_BIT  = 7;
  localparam logic [3:0] SEL_NMI = 4'hC;
  localparam logic [3:0] SEL_RST = 4'hD;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int TMO_BYTES = 3,
  localparam int CNT_W = TMO_BYTES * 8
) (
  input  logic             clk,
  input  logic             core_rst_n,
  input  logic             por_rst_n,
  input  logic             host_wr,
  input  logic             host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             expire_i,
  output logic             en_o,
  output logic [3:0]       sel_o,
  output logic [CNT_W-1:0] tmo_o,
  output logic             load_o,
  output logic             kick_o,
  output logic             fired_o
);
  logic [7:0] idx_q, idx_d;
  logic [7:0] ctrl_q, ctrl_d;
  logic [3:0] ssel_q, ssel_d;
  logic [TMO_BYTES-1:0][7:0] tmo_q;
  logic fired_q, fired_d;
  logic wr_idx, wr_dat;

  assign wr_idx = host_wr && !host_addr;
  assign wr_dat = host_wr && host_addr;

  always_comb begin
    idx_d   = wr_idx ? host_wdata : idx_q;
    ctrl_d  = (wr_dat && idx_q == IDX_CTRL) ? host_wdata : ctrl_q;
    ssel_d  = (wr_dat && idx_q == IDX_SSEL) ? host_wdata[7:4] : ssel_q;
    fired_d = fired_q;
    if (wr_dat && idx_q == IDX_KICK && !host_wdata[FIRED_BIT]) fired_d = 1'b0;
    if (expire_i) fired_d = 1'b1;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      idx_q  <= 8'h00;
      ctrl_q <= 8'h00;
      ssel_q <= 4'h0;
    end else begin
      idx_q  <= idx_d;
      ctrl_q <= ctrl_d;
      ssel_q <= ssel_d;
    end
  end

  generate
    for (genvar g = 0; g < TMO_BYTES; g++) begin : g_tmo
      logic hit;
      assign hit = wr_dat && (idx_q == IDX_TMO0 + 8'(g));
      always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) tmo_q[g] <= 8'h00;
        else if (hit)    tmo_q[g] <= host_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) fired_q <= 1'b0;
    else            fired_q <= fired_d;
  end

  assign en_o    = ctrl_q[EN_BIT];
  assign sel_o   = ssel_q;
  assign tmo_o   = tmo_q;
  assign fired_o = fired_q;
  assign load_o  = wr_dat && idx_q == IDX_CTRL && host_wdata[EN_BIT] && !ctrl_q[EN_BIT];
  assign kick_o  = wr_dat && idx_q == IDX_KICK && host_wdata[KICK_BIT];

  always_comb begin
    host_rdata = 8'h00;
    if (!host_addr) host_rdata = idx_q;
    else begin
      if (idx_q == IDX_CTRL) host_rdata = ctrl_q;
      if (idx_q == IDX_SSEL) host_rdata = {ssel_q, 4'h0};
      if (idx_q == IDX_KICK) host_rdata = {fired_q, 7'h00};
      for (int b = 0; b < TMO_BYTES; b++)
        if (idx_q == IDX_TMO0 + 8'(b)) host_rdata = tmo_q[b];
    end
  end

  AST_FIRED_SET: assert property (@(posedge clk) disable iff (!core_rst_n)
    expire_i |=> fired_q) else $error("fired flag not set");  // R7
  AST_KICK_READS_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
    (host_addr && idx_q == IDX_KICK) |-> !host_rdata[KICK_BIT]) else $error("kick bit read 1");  // R5
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_ce;

  always_comb begin
    expire_o = en_i && tick_en && !kick_i && (cnt_q == '0);
    cnt_ce   = load_i || (en_i && (kick_i || tick_en));
    if (load_i || (en_i && kick_i) || expire_o) cnt_d = tmo_i;
    else                                         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(tmo_i))) else $error("load value wrong");  // R2
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i) |=> $stable(cnt_q)) else $error("count moved while disabled");  // R8
  AST_NO_EXPIRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !expire_o) else $error("expiry while disabled");  // R8
endmodule

// File: rtl/wdt_route.sv
module wdt_route
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire_i,
  input  logic [3:0] sel_i,
  output logic       rst_o,
  output logic       nmi_o
);
  logic rst_q, rst_d, nmi_q, nmi_d;

  always_comb begin
    rst_d = expire_i && (sel_i == SEL_RST);
    nmi_d = expire_i && (sel_i == SEL_NMI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      nmi_q <= nmi_d;
    end
  end

  assign rst_o = rst_q;
  assign nmi_o = nmi_q;

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_q && nmi_q)) else $error("both outputs pulsed");  // R6
  AST_RST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> ($past(sel_i) == SEL_RST)) else $error("reset pulse without reset code");  // R6
endmodule

// File: rtl/wdt_indexed.sv
module wdt_indexed
  import wdt_pkg::*;
#(
  parameter int TMO_BYTES = 3,
  localparam int CNT_W = TMO_BYTES * 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       host_wr,
  input  logic       host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       wdt_rst_o,
  output logic       wdt_nmi_o
);
  logic core_rst_n, por_rst_n;
  logic en, load, kick, expire, fired;
  logic [3:0] sel;
  logic [CNT_W-1:0] tmo;

  wdt_rst_sync u_sync_core (.clk(clk), .arst_n(rst_n && por_n), .srst_n(core_rst_n));
  wdt_rst_sync u_sync_por  (.clk(clk), .arst_n(por_n),          .srst_n(por_rst_n));

  wdt_regfile #(.TMO_BYTES(TMO_BYTES)) u_regs (
    .clk(clk), .core_rst_n(core_rst_n), .por_rst_n(por_rst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .expire_i(expire), .en_o(en), .sel_o(sel),
    .tmo_o(tmo), .load_o(load), .kick_o(kick), .fired_o(fired)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(core_rst_n), .tick_en(tick_en), .en_i(en),
    .load_i(load), .kick_i(kick), .tmo_i(tmo), .expire_o(expire)
  );

  wdt_route u_route (
    .clk(clk), .rst_n(core_rst_n), .expire_i(expire), .sel_i(sel),
    .rst_o(wdt_rst_o), .nmi_o(wdt_nmi_o)
  );

  AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wdt_rst_o || wdt_nmi_o) |-> fired) else $error("pulse without fired flag");  // R7
endmodule

// File: tb/wdt_indexed_bench.sv
module wdt_indexed_bench;
  logic clk = 1'b0;
  logic por_n, rst_n, tick_en, host_wr, host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic wdt_rst_o, wdt_nmi_o;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  wdt_indexed u_wdt_indexed (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .wdt_rst_o(wdt_rst_o), .wdt_nmi_o(wdt_nmi_o)
  );

  // {index, write data, expected readback}
  localparam logic [23:0] VEC [8] = '{
    24'h37_00_00, 24'h38_D5_D0, 24'h39_12_12, 24'h3A_34_34,
    24'h3B_56_56, 24'h3C_7F_00, 24'h50_AA_00, 24'h38_C3_C0
  };
  localparam string VREQ [8] = '{"R2", "R3", "R4", "R4", "R4", "R5", "R9", "R3"};

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic port_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    port_wr(1'b0, idx);
    port_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    port_wr(1'b0, idx);
    host_addr = 1'b1;
    #1 d = host_rdata;
  endtask

  task automatic tick(input int n, output int rst_cnt, output int nmi_cnt);
    rst_cnt = 0; nmi_cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      rst_cnt += int'(wdt_rst_o); nmi_cnt += int'(wdt_nmi_o);
    end
  endtask

  task automatic do_reset(input logic full);
    @(negedge clk);
    rst_n = 1'b0; if (full) por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic arm(input logic [7:0] sel, input logic [7:0] t0, input logic [7:0] t1);
    reg_wr(8'h37, 8'h00);
    reg_wr(8'h39, t0); reg_wr(8'h3A, t1); reg_wr(8'h3B, 8'h00);
    reg_wr(8'h38, sel);
    reg_wr(8'h3C, 8'h00);
    reg_wr(8'h37, 8'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int r, n;
    por_n = 1'b0; rst_n = 1'b0; tick_en = 1'b0;
    host_wr = 1'b0; host_addr = 1'b0; host_wdata = 8'h00;
    do_reset(1'b1);

    // R10 reset state
    check(wdt_rst_o == 1'b0 && wdt_nmi_o == 1'b0, "R10", {wdt_rst_o, wdt_nmi_o}, 0);
    reg_rd(8'h37, rd); check(rd == 8'h00, "R10", rd, 8'h00);
    reg_rd(8'h3B, rd); check(rd == 8'h00, "R10", rd, 8'h00);

    // Vector table: write then read back
    for (int v = 0; v < 8; v++) begin
      reg_wr(VEC[v][23:16], VEC[v][15:8]);
      reg_rd(VEC[v][23:16], rd);
      check(rd == VEC[v][7:0], VREQ[v], rd, VEC[v][7:0]);
    end
    // R1: offset 0 reads back index
    port_wr(1'b0, 8'h3A); host_addr = 1'b0; #1;
    check(host_rdata == 8'h3A, "R1", host_rdata, 8'h3A);
    // R9: write to unused index must not disturb registers
    reg_rd(8'h39, rd); check(rd == 8'h12, "R9", rd, 8'h12);

    // R4/R6: reset route, timeout 2 -> expiry on tick 3
    arm(8'hD0, 8'h02, 8'h00);
    tick(2, r, n); check(r == 0 && n == 0, "R4", r + n, 0);
    tick(1, r, n); check(r == 1 && n == 0, "R6", {r[3:0], n[3:0]}, 8'h10);
    @(negedge clk); check(wdt_rst_o == 1'b0, "R6", wdt_rst_o, 0);
    // R7: fired set; writing 1 keeps it; writing 0 clears
    reg_rd(8'h3C, rd); check(rd == 8'h80, "R7", rd, 8'h80);
    reg_wr(8'h3C, 8'h80);
    reg_rd(8'h3C, rd); check(rd == 8'h80, "R7", rd, 8'h80);
    reg_wr(8'h3C, 8'h00);
    reg_rd(8'h3C, rd); check(rd == 8'h00, "R7", rd, 8'h00);
    // R6: counter kept running after expiry
    tick(3, r, n); check(r == 1, "R6", r, 1);

    // R6 NMI route
    arm(8'hC0, 8'h02, 8'h00);
    tick(3, r, n); check(r == 0 && n == 1, "R6", {r[3:0], n[3:0]}, 8'h01);

    // R6 unknown code: no pulse, flag still set
    arm(8'hE0, 8'h02, 8'h00);
    tick(3, r, n); check(r == 0 && n == 0, "R6", r + n, 0);
    reg_rd(8'h3C, rd); check(rd == 8'h80, "R7", rd, 8'h80);

    // R5 kick mid-count
    arm(8'hD0, 8'h02, 8'h00);
    tick(2, r, n);
    reg_wr(8'h3C, 8'h40);
    tick(2, r, n); check(r == 0, "R5", r, 0);
    tick(1, r, n); check(r == 1, "R5", r, 1);

    // R2: writing enable again while enabled does not reload
    tick(2, r, n);
    reg_wr(8'h37, 8'h40);
    tick(1, r, n); check(r == 1, "R2", r, 1);

    // R8 freeze while disabled, R2 reload on re-enable
    arm(8'hD0, 8'h02, 8'h00);
    tick(2, r, n);
    reg_wr(8'h37, 8'h00);
    reg_wr(8'h3C, 8'h40);
    tick(5, r, n); check(r == 0, "R8", r, 0);
    reg_rd(8'h3C, rd); check(rd == 8'h00, "R8", rd, 8'h00);
    reg_wr(8'h37, 8'h40);
    tick(2, r, n); check(r == 0, "R2", r, 0);
    tick(1, r, n); check(r == 1, "R2", r, 1);

    // R4 middle byte: timeout 0x000100 -> expiry on tick 257
    arm(8'hD0, 8'h00, 8'h01);
    tick(256, r, n); check(r == 0, "R4", r, 0);
    tick(1, r, n); check(r == 1, "R4", r, 1);

    // R7 flag survives system reset, cleared by power-on reset
    reg_wr(8'h37, 8'h00);
    do_reset(1'b0);
    reg_rd(8'h3C, rd); check(rd == 8'h80, "R7", rd, 8'h80);
    reg_rd(8'h38, rd); check(rd == 8'h00, "R10", rd, 8'h00);
    do_reset(1'b1);
    reg_rd(8'h3C, rd); check(rd == 8'h00, "R7", rd, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule